// File: doc/BRIEF.md
# Paired Capture Time Base with 32-bit Cascade

This block holds two 16-bit time bases that feed input-capture logic. Unit 0 is the odd unit and unit 1 is the even unit. Each unit picks one of several shared source lines. Every source line has an enable level and a pulse. A unit also runs in one of two start modes. In synchronous mode the unit is held at zero while its source is disabled, and each source pulse restarts it. In trigger mode the unit waits at zero for a source pulse, raises a status flag when the pulse arrives, and then counts freely until software clears the flag.

When both cascade requests are set, the two units act as one 32-bit counter. Unit 0 supplies the low half and unit 1 supplies the high half. Each time the low half rolls over, the high half steps by one. In this mode the high half ignores its own mode, source and clear controls and follows unit 0. A capture strobe copies both halves into one 32-bit register in the same cycle.

Top module: `capture_timebase_pair`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `lo_cnt`, `hi_cnt`, `trig_stat` and `cap_val` are all zero.
- R2: A synchronous-mode unit whose source is active steps by one on every edge where `clk_en` is high. It holds its value on edges where `clk_en` is low.
- R3: A synchronous-mode unit is held at zero while its selected source enable is low. It is also held at zero while its select value is 0, which means no source.
- R4: In synchronous mode, a source pulse together with `clk_en` sets the count to zero at that edge. A pulse without `clk_en` has no effect.
- R5: A trigger-mode unit with its status bit low stays at zero. A source pulse together with `clk_en` sets the status bit while the count stays at zero. After that, the count steps on every enabled edge.
- R6: `trig_clr` for a trigger-mode unit clears both its status bit and its count at the next edge, and the unit re-arms. A clear overrides a trigger pulse arriving in the same cycle.
- R7: Cascading happens only when both bits of `casc_req` are 1. With only one bit set, the two units count independently and a roll-over of unit 0 does not reach unit 1.
- R8: When cascaded, a roll-over of `lo_cnt` from all-ones to zero raises `hi_cnt` by one at the same edge. Any event that zeroes the low half also zeroes the high half.
- R9: When cascaded, unit 1's `hi_sel`, `trig_mode[1]` and `trig_clr[1]` have no effect, and `trig_stat[1]` reads 0.
- R10: On an edge where `cap_strobe` is high, `cap_val` takes `{hi_cnt, lo_cnt}` as they were before that edge. Both halves are latched together.
- R11: A select value k from 1 to NSRC uses source line k-1, both its enable and its pulse. Any value above NSRC means no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Time-base tick enable |
| src_en | input | NSRC | Enable level of each source line |
| src_pulse | input | NSRC | Sync/trigger pulse of each source line |
| casc_req | input | 2 | Cascade request per unit (bit 0 = odd unit) |
| lo_sel | input | SELW | Source select of unit 0 (0 = none) |
| hi_sel | input | SELW | Source select of unit 1 (0 = none) |
| trig_mode | input | 2 | Per-unit mode, 1 = trigger, 0 = synchronous |
| trig_clr | input | 2 | Per-unit trigger status clear |
| cap_strobe | input | 1 | Capture both halves |
| lo_cnt | output | CW | Count of unit 0 / low half |
| hi_cnt | output | CW | Count of unit 1 / high half |
| cnt_wide | output | 2*CW | `{hi_cnt, lo_cnt}` |
| trig_stat | output | 2 | Per-unit trigger status |
| cap_val | output | 2*CW | Last captured wide value |

## Verification
Two things can land on the same edge in the cascaded counter: the low half rolling over, which carries into the high half, and a source pulse, which restarts the pair. The bench provokes this by running the pair until the low half is all ones, then applying a sync pulse together with `clk_en`. The result is judged correct if both halves read zero and the high half shows no increment. A capture strobe is also placed on the roll-over edge itself. The captured word must hold the pre-edge value, and the counter must move to the carried value.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC  = 2'd0,
    MODE_TRIG  = 2'd1,
    MODE_SLAVE = 2'd2
  } ctb_mode_e;
endpackage

// File: rtl/ctb_src_select.sv
module ctb_src_select #(
  parameter int NSRC = 4,
  parameter int SELW = $clog2(NSRC + 1)
) (
  input  logic [SELW-1:0] sel,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_pulse,
  output logic            act,
  output logic            pls
);
  // code 0 and codes above NSRC select nothing
  always_comb begin
    act = 1'b0;
    pls = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (sel == SELW'(k + 1)) begin
        act = src_en[k];
        pls = src_pulse[k];
      end
    end
  end
endmodule

// File: rtl/ctb_unit.sv
module ctb_unit
  import ctb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctb_mode_e     mode,
  input  logic          clk_en,
  input  logic          src_act,
  input  logic          src_pls,
  input  logic          trig_clr,
  input  logic          m_clr,
  input  logic          m_inc,
  output logic [CW-1:0] cnt,
  output logic          stat,
  output logic          clr_o,
  output logic          inc_o
);
  // what this unit does at the coming edge; a slave unit just follows
  always_comb begin
    clr_o = 1'b0;
    inc_o = 1'b0;
    unique case (mode)
      MODE_TRIG: begin
        clr_o = trig_clr || !stat;
        inc_o = !trig_clr && stat && clk_en;
      end
      MODE_SLAVE: begin
        clr_o = m_clr;
        inc_o = m_inc;
      end
      default: begin
        clr_o = !src_act || (clk_en && src_pls);
        inc_o = src_act && clk_en && !src_pls;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      stat <= 1'b0;
    end else begin
      if (clr_o)      cnt <= '0;
      else if (inc_o) cnt <= cnt + 1'b1;

      if (mode == MODE_TRIG) begin
        if (trig_clr)                        stat <= 1'b0;
        else if (!stat && clk_en && src_pls) stat <= 1'b1;
      end else begin
        stat <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctb_capture.sv
module ctb_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (strobe) dout <= din;
  end
endmodule

// File: rtl/capture_timebase_pair.sv
module capture_timebase_pair
  import ctb_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NSRC = 4,
  parameter int SELW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clk_en,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_pulse,
  input  logic [1:0]      casc_req,
  input  logic [SELW-1:0] lo_sel,
  input  logic [SELW-1:0] hi_sel,
  input  logic [1:0]      trig_mode,
  input  logic [1:0]      trig_clr,
  input  logic            cap_strobe,
  output logic [CW-1:0]   lo_cnt,
  output logic [CW-1:0]   hi_cnt,
  output logic [2*CW-1:0] cnt_wide,
  output logic [1:0]      trig_stat,
  output logic [2*CW-1:0] cap_val
);
  localparam int          WW    = 2 * CW;
  localparam logic [CW-1:0] ALL1 = '1;

  logic            casc;
  logic [SELW-1:0] sel_v  [2];
  logic [1:0]      act_v, pls_v, clr_v, inc_v;
  ctb_mode_e       mode_v [2];
  logic [CW-1:0]   cnt_v  [2];

  assign casc     = &casc_req;
  assign sel_v[0] = lo_sel;
  assign sel_v[1] = hi_sel;

  assign mode_v[0] = trig_mode[0] ? MODE_TRIG : MODE_SYNC;
  assign mode_v[1] = casc ? MODE_SLAVE : (trig_mode[1] ? MODE_TRIG : MODE_SYNC);

  for (genvar u = 0; u < 2; u++) begin : g_unit
    ctb_src_select #(.NSRC(NSRC), .SELW(SELW)) u_sel (
      .sel      (sel_v[u]),
      .src_en   (src_en),
      .src_pulse(src_pulse),
      .act      (act_v[u]),
      .pls      (pls_v[u])
    );

    ctb_unit #(.CW(CW)) u_tb (
      .clk     (clk),
      .rst     (rst),
      .mode    (mode_v[u]),
      .clk_en  (clk_en),
      .src_act (act_v[u]),
      .src_pls (pls_v[u]),
      .trig_clr(trig_clr[u]),
      .m_clr   ((u == 1) ? clr_v[0] : 1'b0),
      .m_inc   ((u == 1) ? (inc_v[0] && cnt_v[0] == ALL1) : 1'b0),
      .cnt     (cnt_v[u]),
      .stat    (trig_stat[u]),
      .clr_o   (clr_v[u]),
      .inc_o   (inc_v[u])
    );
  end

  assign lo_cnt   = cnt_v[0];
  assign hi_cnt   = cnt_v[1];
  assign cnt_wide = {cnt_v[1], cnt_v[0]};

  ctb_capture #(.DW(WW)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .strobe(cap_strobe),
    .din   (cnt_wide),
    .dout  (cap_val)
  );
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
  parameter int CW   = 16,
  parameter int NSRC = 4,
  parameter int SELW = $clog2(NSRC + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            clk_en,
  input logic [NSRC-1:0] src_en,
  input logic [NSRC-1:0] src_pulse,
  input logic [1:0]      casc_req,
  input logic [SELW-1:0] lo_sel,
  input logic [1:0]      trig_mode,
  input logic [1:0]      trig_clr,
  input logic            cap_strobe,
  input logic [CW-1:0]   lo_cnt,
  input logic [CW-1:0]   hi_cnt,
  input logic [1:0]      trig_stat,
  input logic [2*CW-1:0] cap_val
);
  localparam logic [CW-1:0] TOP = '1;
  logic lo_on, lo_pl;
  always_comb begin
    lo_on = 1'b0;
    lo_pl = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (int'(lo_sel) == k + 1) begin
        lo_on = src_en[k];
        lo_pl = src_pulse[k];
      end
  end

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!trig_mode[0] && lo_on && clk_en && !lo_pl) |=> lo_cnt == $past(lo_cnt) + 1'b1);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && !trig_clr[0] && (trig_mode[0] ? trig_stat[0] : lo_on)) |=> $stable(lo_cnt));
  a_r3_held_zero: assert property (@(posedge clk) disable iff (rst)
    (!trig_mode[0] && !lo_on) |=> lo_cnt == '0);
  a_r5_armed_zero: assert property (@(posedge clk) disable iff (rst)
    (trig_mode[0] && !trig_stat[0]) |=> lo_cnt == '0);
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (trig_mode[0] && trig_clr[0]) |=> (lo_cnt == '0 && !trig_stat[0]));
  a_r8_carry_only: assert property (@(posedge clk) disable iff (rst)
    (&casc_req && $past(&casc_req) && hi_cnt != $past(hi_cnt)) |->
      (hi_cnt == '0 || ($past(lo_cnt) == TOP && lo_cnt == '0 && hi_cnt == $past(hi_cnt) + 1'b1)));
  a_r9_slave_stat: assert property (@(posedge clk) disable iff (rst)
    (&casc_req) |=> !trig_stat[1]);
  a_r10_capture: assert property (@(posedge clk) disable iff (rst)
    cap_strobe |=> cap_val == $past({hi_cnt, lo_cnt}));
endmodule

bind capture_timebase_pair ctb_checker #(.CW(CW), .NSRC(NSRC), .SELW(SELW)) u_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en), .src_en(src_en), .src_pulse(src_pulse),
  .casc_req(casc_req), .lo_sel(lo_sel), .trig_mode(trig_mode), .trig_clr(trig_clr),
  .cap_strobe(cap_strobe), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .trig_stat(trig_stat),
  .cap_val(cap_val)
);

// File: tb/sim_capture_timebase_pair.sv
module sim_capture_timebase_pair;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int NSRC = 4;
  localparam int SELW = $clog2(NSRC + 1);
  localparam int WW   = 2 * CW;

  logic clk = 1'b0;
  logic rst, clk_en, cap_strobe;
  logic [NSRC-1:0] src_en, src_pulse;
  logic [1:0] casc_req, trig_mode, trig_clr, trig_stat;
  logic [SELW-1:0] lo_sel, hi_sel;
  logic [CW-1:0] lo_cnt, hi_cnt;
  logic [WW-1:0] cnt_wide, cap_val;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  capture_timebase_pair #(.CW(CW), .NSRC(NSRC)) u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .src_en(src_en), .src_pulse(src_pulse),
    .casc_req(casc_req), .lo_sel(lo_sel), .hi_sel(hi_sel), .trig_mode(trig_mode),
    .trig_clr(trig_clr), .cap_strobe(cap_strobe), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
    .cnt_wide(cnt_wide), .trig_stat(trig_stat), .cap_val(cap_val)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; clk_en = 1'b0; cap_strobe = 1'b0;
    src_en = '0; src_pulse = '0; casc_req = '0; trig_mode = '0; trig_clr = '0;
    lo_sel = '0; hi_sel = '0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    tick(1);
    check("R1 lo", lo_cnt, 0);
    check("R1 hi", hi_cnt, 0);
    check("R1 stat", trig_stat, 0);
    check("R1 cap", cap_val, 0);
  endtask

  task automatic t_sync_count();
    do_reset();
    lo_sel = 3'd1; src_en = 4'b0001; clk_en = 1'b1;
    tick(5);
    check("R2 steps", lo_cnt, 5);
    check("R3 hi no source", hi_cnt, 0);
    clk_en = 1'b0;
    tick(2);
    check("R2 hold", lo_cnt, 5);
    src_en = 4'b0000;
    tick(1);
    check("R3 disabled zero", lo_cnt, 0);
  endtask

  task automatic t_sync_pulse();
    do_reset();
    lo_sel = 3'd1; src_en = 4'b0001; clk_en = 1'b1;
    tick(3);
    clk_en = 1'b0; src_pulse = 4'b0001;
    tick(1);
    check("R4 pulse w/o clk_en", lo_cnt, 3);
    clk_en = 1'b1;
    tick(1);
    check("R4 restart", lo_cnt, 0);
    src_pulse = '0;
    tick(1);
    check("R4 after restart", lo_cnt, 1);
  endtask

  task automatic t_select();
    do_reset();
    lo_sel = 3'd3; src_en = 4'b0100; clk_en = 1'b1;
    tick(4);
    check("R11 line 2", lo_cnt, 4);
    lo_sel = 3'd5; src_en = 4'b1111;
    tick(1);
    check("R11 out of range", lo_cnt, 0);
  endtask

  task automatic t_trigger();
    do_reset();
    trig_mode = 2'b01; lo_sel = 3'd2; clk_en = 1'b1;
    tick(3);
    check("R5 armed cnt", lo_cnt, 0);
    check("R5 armed stat", trig_stat[0], 0);
    src_pulse = 4'b0010;
    tick(1);
    src_pulse = '0;
    check("R5 stat set", trig_stat[0], 1);
    check("R5 cnt at trigger", lo_cnt, 0);
    tick(4);
    check("R5 free run", lo_cnt, 4);
    // clear colliding with a new trigger pulse
    trig_clr = 2'b01; src_pulse = 4'b0010;
    tick(1);
    trig_clr = '0; src_pulse = '0;
    check("R6 clear cnt", lo_cnt, 0);
    check("R6 clear stat", trig_stat[0], 0);
    tick(2);
    check("R6 re-armed", lo_cnt, 0);
  endtask

  task automatic t_one_request();
    do_reset();
    casc_req = 2'b01; lo_sel = 3'd1; hi_sel = 3'd2; src_en = 4'b0001; clk_en = 1'b1;
    tick((1 << CW) - 1);
    check("R7 lo at top", lo_cnt, (1 << CW) - 1);
    tick(1);
    check("R7 lo wrapped", lo_cnt, 0);
    check("R7 hi independent", hi_cnt, 0);
  endtask

  task automatic t_cascade();
    do_reset();
    casc_req = 2'b11; lo_sel = 3'd1; src_en = 4'b0001;
    hi_sel = 3'd0; trig_mode = 2'b10; trig_clr = 2'b10; clk_en = 1'b1;
    tick((1 << CW) - 1);
    check("R8 pre-wrap lo", lo_cnt, (1 << CW) - 1);
    check("R9 hi own ctrl ignored", hi_cnt, 0);
    cap_strobe = 1'b1;
    tick(1);
    cap_strobe = 1'b0;
    check("R10 capture pre-edge", cap_val, (1 << CW) - 1);
    check("R8 carry", cnt_wide, 1 << CW);
    tick(1 << CW);
    check("R8 second carry", cnt_wide, 2 << CW);
    check("R9 hi stat", trig_stat[1], 0);
    tick((1 << CW) - 1);
    // roll-over and sync pulse on the same edge
    src_pulse = 4'b0001;
    tick(1);
    src_pulse = '0;
    check("R8 pulse beats carry", cnt_wide, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_sync_count();
        t_sync_pulse();
        t_select();
        t_trigger();
        t_one_request();
        t_cascade();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule